// File: doc/BRIEF.md
# Memory response ordering unit

This unit sits between the stage that issues global memory instructions and the stage that writes results back to registers. It counts outstanding requests per kind, records each response as it comes back from memory, and presents completed responses one at a time to writeback over a valid/ready handshake. Only the sequence tag and the kind of each request pass through it. Data payloads, the memory system and the register file are handled elsewhere.

A static mode input, sampled while reset is held and not changed afterwards, picks one of two release policies.

- **Program-order mode (`mode_ooo = 0`, the default):**
  - Every non-fence request reserves a slot in a circular ordering buffer when it issues. The slot records its tag and a cleared done flag.
  - A returning response looks up its slot by comparing tags, and sets that slot's done flag.
  - Only the oldest slot is ever offered to writeback, and only once its done flag is set.
- **Arrival-order mode (`mode_ooo = 1`):**
  - Responses go into two queues, one for loads and atomics and one for stores, in the order they arrive.
  - The load queue has priority when the next item is chosen.

The writeback side is a small state machine with four states:

| State | Meaning |
|---|---|
| `S_IDLE` | Nothing is offered. |
| `S_ROB` | The head of the ordering buffer is offered. |
| `S_LDQ` | The head of the load queue is offered. |
| `S_STQ` | The head of the store queue is offered. |

It moves as follows:

- **Hold:** from any busy state, it stays put while `wb_ready` is low.
- **Select:** from `S_IDLE`, or on an accepted handshake, it picks the next source from what remains after the pop. The choice is `S_ROB` in program-order mode, or `S_LDQ` before `S_STQ` in arrival-order mode.
- **Drain:** if nothing remains, it returns to `S_IDLE`.

Top module: `mem_resp_order`

## Requirements
- R1: After reset `wb_valid` is 0, and `iss_ready` is 1 for every kind. Kind codes are 0 load, 1 atomic, 2 store, 3 fence.
- R2: In program-order mode, accepted non-fence requests are delivered at writeback in issue order, whatever order their responses return in.
- R3: In program-order mode, a completed younger request is not offered while any older request is still outstanding.
- R4: Fence requests (kind 3) are always accepted. They use no ordering slot and no in-flight credit, and never appear at writeback.
- R5: In program-order mode, a response whose tag matches no outstanding slot raises `rsp_err` in the same cycle and changes nothing.
- R6: In arrival-order mode, loads and atomics are delivered in their response arrival order, and so are stores.
- R7: In arrival-order mode, whenever a new item is selected and the load queue is non-empty, a load-queue item is chosen before any store.
- R8: Loads plus atomics in flight, and stores in flight, are each capped at `INFLIGHT_MAX` (default 6). At the cap, `iss_ready` is 0 for that kind only.
- R9: A writeback handshake releases one in-flight credit of the delivered kind. A capped kind becomes issuable again in the cycle after the handshake.
- R10: In arrival-order mode, a response whose queue is full (`RSPQ_DEPTH`, default 4) raises `rsp_err` and is dropped.
- R11: While `wb_valid` is 1 and `wb_ready` is 0, `wb_valid`, `wb_tag` and `wb_kind` are held unchanged.
- R12: With nothing already offered, a response sampled at clock edge k makes `wb_valid` rise after edge k+1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_ooo | input | 1 | 0 = program order, 1 = arrival order (static) |
| iss_valid | input | 1 | Issue request present |
| iss_tag | input | TAG_W | Sequence tag of the request |
| iss_kind | input | 2 | Request kind |
| iss_ready | output | 1 | Request of this kind may issue this cycle |
| rsp_valid | input | 1 | Memory response present |
| rsp_tag | input | TAG_W | Tag of the response |
| rsp_kind | input | 2 | Kind of the response |
| rsp_err | output | 1 | Response unmatched or its queue is full |
| wb_valid | output | 1 | Response offered to writeback |
| wb_tag | output | TAG_W | Tag of the offered response |
| wb_kind | output | 2 | Kind of the offered response |
| wb_ready | input | 1 | Writeback accepts the offer |

## Verification
Issue and response inputs are driven two nanoseconds after a rising edge and read back at the next falling edge. `iss_ready` and `rsp_err` are therefore checked in the same cycle as their stimulus. A credit freed by a handshake is checked one cycle after that handshake. A response recorded at one edge is expected at writeback after the following edge, so the bench checks `wb_valid` low, then high, on two successive falling edges. All other deliveries are checked by a scoreboard that pops an expected tag and kind on every falling edge where `wb_valid` and `wb_ready` are both high. This makes the ordering checks independent of the exact delivery cycle.

// File: rtl/mro_pkg.sv
package mro_pkg;

    typedef enum logic [1:0] {
        K_LOAD   = 2'd0,
        K_ATOMIC = 2'd1,
        K_STORE  = 2'd2,
        K_FENCE  = 2'd3
    } kind_e;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_ROB  = 2'd1,
        S_LDQ  = 2'd2,
        S_STQ  = 2'd3
    } wb_state_e;

    function automatic logic kind_is_ld(kind_e k);
        return (k == K_LOAD) || (k == K_ATOMIC);
    endfunction

endpackage

// File: rtl/mro_credit.sv
module mro_credit #(
    parameter int MAX = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    input  logic dec,
    output logic at_cap
);
    localparam int CW = $clog2(MAX + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case ({inc, dec})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    assign at_cap = (cnt_q == CW'(MAX));

    a_r8_within_cap: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAX));
    a_r8_no_issue_at_cap: assert property (@(posedge clk) disable iff (!rst_n)
        inc |-> !at_cap);
    a_r9_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        dec |-> (cnt_q != '0));
endmodule

// File: rtl/mro_fifo.sv
module mro_fifo #(
    parameter int W     = 10,
    parameter int DEPTH = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         push,
    input  logic [W-1:0] din,
    input  logic         pop,
    output logic [W-1:0] dout,
    output logic         empty,
    output logic         full,
    output logic         multi
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_q, wr_q;
    logic [CW-1:0] cnt_q;

    function automatic logic [AW-1:0] bump(logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rd_q  <= '0;
            wr_q  <= '0;
            cnt_q <= '0;
        end else begin
            if (push) wr_q <= bump(wr_q);
            if (pop)  rd_q <= bump(rd_q);
            unique case ({push, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (push) mem[wr_q] <= din;
    end

    assign dout  = mem[rd_q];
    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CW'(DEPTH));
    assign multi = (cnt_q > CW'(1));

    a_r10_no_push_when_full: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    a_r6_no_pop_when_empty: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
endmodule

// File: rtl/mro_rob.sv
module mro_rob
    import mro_pkg::*;
#(
    parameter int TAG_W = 8,
    parameter int DEPTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             alloc_en,
    input  logic [TAG_W-1:0] alloc_tag,
    input  kind_e            alloc_kind,
    input  logic             mark_en,
    input  logic [TAG_W-1:0] mark_tag,
    output logic             mark_hit,
    input  logic             pop,
    output logic             head_rdy,
    output logic             next_rdy,
    output logic [TAG_W-1:0] head_tag,
    output kind_e            head_kind,
    output logic             full
);
    localparam int AW = $clog2(DEPTH);
    localparam int CW = AW + 1;

    logic [DEPTH-1:0] vld_v, done_v, hit_v;
    logic [TAG_W-1:0] tag_a  [DEPTH];
    kind_e            kind_a [DEPTH];
    logic [AW-1:0]    head_q, tail_q, head_nx;
    logic [CW-1:0]    cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (alloc_en) tail_q <= tail_q + 1'b1;
            if (pop)      head_q <= head_q + 1'b1;
            unique case ({alloc_en, pop})
                2'b10:   cnt_q <= cnt_q + 1'b1;
                2'b01:   cnt_q <= cnt_q - 1'b1;
                default: cnt_q <= cnt_q;
            endcase
        end
    end

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        logic             s_vld, s_done;
        logic [TAG_W-1:0] s_tag;
        kind_e            s_kind;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                s_vld  <= 1'b0;
                s_done <= 1'b0;
            end else if (alloc_en && tail_q == AW'(i)) begin
                s_vld  <= 1'b1;
                s_done <= 1'b0;
            end else if (pop && head_q == AW'(i)) begin
                s_vld  <= 1'b0;
                s_done <= 1'b0;
            end else if (mark_en && hit_v[i]) begin
                s_done <= 1'b1;
            end
        end

        always_ff @(posedge clk) begin
            if (alloc_en && tail_q == AW'(i)) begin
                s_tag  <= alloc_tag;
                s_kind <= alloc_kind;
            end
        end

        assign vld_v[i]  = s_vld;
        assign done_v[i] = s_done;
        assign tag_a[i]  = s_tag;
        assign kind_a[i] = s_kind;
        assign hit_v[i]  = s_vld && !s_done && (s_tag == mark_tag);
    end

    assign head_nx   = head_q + 1'b1;
    assign mark_hit  = |hit_v;
    assign head_rdy  = vld_v[head_q] && done_v[head_q];
    assign next_rdy  = vld_v[head_nx] && done_v[head_nx];
    assign head_tag  = tag_a[head_q];
    assign head_kind = kind_a[head_q];
    assign full      = (cnt_q == CW'(DEPTH));

    a_r4_fence_no_slot: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> (alloc_kind != K_FENCE));
    a_r2_no_alloc_full: assert property (@(posedge clk) disable iff (!rst_n)
        alloc_en |-> !full);
    a_r3_pop_only_done: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> head_rdy);
    a_r5_unique_match: assert property (@(posedge clk) disable iff (!rst_n)
        mark_en |-> $countones(hit_v) <= 1);
endmodule

// File: rtl/mem_resp_order.sv
module mem_resp_order
    import mro_pkg::*;
#(
    parameter int TAG_W        = 8,
    parameter int ROB_DEPTH    = 16,
    parameter int RSPQ_DEPTH   = 4,
    parameter int INFLIGHT_MAX = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             mode_ooo,
    input  logic             iss_valid,
    input  logic [TAG_W-1:0] iss_tag,
    input  logic [1:0]       iss_kind,
    output logic             iss_ready,
    input  logic             rsp_valid,
    input  logic [TAG_W-1:0] rsp_tag,
    input  logic [1:0]       rsp_kind,
    output logic             rsp_err,
    output logic             wb_valid,
    output logic [TAG_W-1:0] wb_tag,
    output logic [1:0]       wb_kind,
    input  logic             wb_ready
);
    localparam int QW = TAG_W + 2;

    kind_e     ik, rk, wk;
    wb_state_e state_q, state_d;

    logic ld_cap, st_cap, rob_full;
    logic iss_fire, wb_fire;
    logic rob_hit, rob_head_rdy, rob_next_rdy, rob_pop;
    logic [TAG_W-1:0] rob_head_tag;
    kind_e rob_head_kind;
    logic ldq_push, stq_push, ldq_pop, stq_pop;
    logic ldq_empty, ldq_full, ldq_multi, stq_empty, stq_full, stq_multi;
    logic [QW-1:0] ldq_dout, stq_dout;
    logic ld_left, st_left, rob_left;

    assign ik = kind_e'(iss_kind);
    assign rk = kind_e'(rsp_kind);

    // issue gating: per-kind credit plus a free slot in program-order mode
    always_comb begin
        unique case (ik)
            K_LOAD, K_ATOMIC: iss_ready = !ld_cap && (mode_ooo || !rob_full);
            K_STORE:          iss_ready = !st_cap && (mode_ooo || !rob_full);
            default:          iss_ready = 1'b1;
        endcase
    end
    assign iss_fire = iss_valid && iss_ready;

    // response routing
    assign ldq_push = mode_ooo && rsp_valid && kind_is_ld(rk) && !ldq_full;
    assign stq_push = mode_ooo && rsp_valid && (rk == K_STORE) && !stq_full;
    always_comb begin
        if (!rsp_valid)
            rsp_err = 1'b0;
        else if (!mode_ooo)
            rsp_err = !rob_hit;
        else if (kind_is_ld(rk))
            rsp_err = ldq_full;
        else if (rk == K_STORE)
            rsp_err = stq_full;
        else
            rsp_err = 1'b1;
    end

    mro_rob #(.TAG_W(TAG_W), .DEPTH(ROB_DEPTH)) u_rob (
        .clk(clk), .rst_n(rst_n),
        .alloc_en(!mode_ooo && iss_fire && ik != K_FENCE),
        .alloc_tag(iss_tag), .alloc_kind(ik),
        .mark_en(!mode_ooo && rsp_valid), .mark_tag(rsp_tag), .mark_hit(rob_hit),
        .pop(rob_pop), .head_rdy(rob_head_rdy), .next_rdy(rob_next_rdy),
        .head_tag(rob_head_tag), .head_kind(rob_head_kind), .full(rob_full)
    );

    mro_fifo #(.W(QW), .DEPTH(RSPQ_DEPTH)) u_ldq (
        .clk(clk), .rst_n(rst_n), .push(ldq_push), .din({rsp_tag, rsp_kind}),
        .pop(ldq_pop), .dout(ldq_dout), .empty(ldq_empty), .full(ldq_full),
        .multi(ldq_multi)
    );

    mro_fifo #(.W(QW), .DEPTH(RSPQ_DEPTH)) u_stq (
        .clk(clk), .rst_n(rst_n), .push(stq_push), .din({rsp_tag, rsp_kind}),
        .pop(stq_pop), .dout(stq_dout), .empty(stq_empty), .full(stq_full),
        .multi(stq_multi)
    );

    mro_credit #(.MAX(INFLIGHT_MAX)) u_ld_credit (
        .clk(clk), .rst_n(rst_n),
        .inc(iss_fire && kind_is_ld(ik)),
        .dec(wb_fire && kind_is_ld(wk)),
        .at_cap(ld_cap)
    );

    mro_credit #(.MAX(INFLIGHT_MAX)) u_st_credit (
        .clk(clk), .rst_n(rst_n),
        .inc(iss_fire && ik == K_STORE),
        .dec(wb_fire && wk == K_STORE),
        .at_cap(st_cap)
    );

    // pops happen on the handshake of the source being offered
    assign wb_fire = wb_valid && wb_ready;
    assign rob_pop = wb_fire && (state_q == S_ROB);
    assign ldq_pop = wb_fire && (state_q == S_LDQ);
    assign stq_pop = wb_fire && (state_q == S_STQ);

    // what is still available once this cycle's pop is applied
    assign rob_left = rob_pop ? rob_next_rdy : rob_head_rdy;
    assign ld_left  = ldq_pop ? ldq_multi : !ldq_empty;
    assign st_left  = stq_pop ? stq_multi : !stq_empty;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_ROB, S_LDQ, S_STQ: begin
                if (wb_ready) begin
                    if (!mode_ooo)    state_d = rob_left ? S_ROB : S_IDLE;
                    else if (ld_left) state_d = S_LDQ;
                    else if (st_left) state_d = S_STQ;
                    else              state_d = S_IDLE;
                end
            end
            default: begin
                if (!mode_ooo)    state_d = rob_left ? S_ROB : S_IDLE;
                else if (ld_left) state_d = S_LDQ;
                else if (st_left) state_d = S_STQ;
                else              state_d = S_IDLE;
            end
        endcase
    end

    // outputs
    always_comb begin
        wb_valid = 1'b1;
        wb_tag   = '0;
        wk       = K_LOAD;
        unique case (state_q)
            S_ROB: begin
                wb_tag = rob_head_tag;
                wk     = rob_head_kind;
            end
            S_LDQ: begin
                wb_tag = ldq_dout[QW-1:2];
                wk     = kind_e'(ldq_dout[1:0]);
            end
            S_STQ: begin
                wb_tag = stq_dout[QW-1:2];
                wk     = kind_e'(stq_dout[1:0]);
            end
            default: wb_valid = 1'b0;
        endcase
    end
    assign wb_kind = wk;

    a_r11_hold_offer: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag) && $stable(wb_kind)));
    a_r7_load_first: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && state_d == S_STQ) |-> ldq_empty);
    a_r3_offer_done_head: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ROB) |-> rob_head_rdy);
    a_r4_no_fence_out: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wk != K_FENCE));
    a_r6_mode_source: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_LDQ || state_q == S_STQ) |-> mode_ooo);
endmodule

// File: tb/mem_resp_order_test.sv
module mem_resp_order_test;
    localparam int TW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mode_ooo = 1'b0;
    logic          iss_valid = 1'b0;
    logic [TW-1:0] iss_tag = '0;
    logic [1:0]    iss_kind = 2'd0;
    logic          iss_ready;
    logic          rsp_valid = 1'b0;
    logic [TW-1:0] rsp_tag = '0;
    logic [1:0]    rsp_kind = 2'd0;
    logic          rsp_err;
    logic          wb_valid;
    logic [TW-1:0] wb_tag;
    logic [1:0]    wb_kind;
    logic          wb_ready = 1'b1;

    int total = 0;
    int bad = 0;
    int cycles = 0;
    logic [TW+1:0] exp_q[$];

    always #4 clk = ~clk;

    mem_resp_order uut (
        .clk(clk), .rst_n(rst_n), .mode_ooo(mode_ooo),
        .iss_valid(iss_valid), .iss_tag(iss_tag), .iss_kind(iss_kind), .iss_ready(iss_ready),
        .rsp_valid(rsp_valid), .rsp_tag(rsp_tag), .rsp_kind(rsp_kind), .rsp_err(rsp_err),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_kind(wb_kind), .wb_ready(wb_ready)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // scoreboard monitor: every handshake must match the next expected item
    always @(negedge clk) begin
        if (rst_n && wb_valid && wb_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R2/R6 unexpected delivery", int'(wb_tag), -1);
            end else begin
                logic [TW+1:0] e;
                e = exp_q.pop_front();
                check({wb_tag, wb_kind} == e, "R2/R6 delivery order",
                      int'({wb_tag, wb_kind}), int'(e));
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles == 20000) begin
            bad++;
            total++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 0);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic issue(input int tag, input int kind);
        @(posedge clk); #2;
        iss_valid = 1'b1; iss_tag = TW'(tag); iss_kind = 2'(kind);
        do @(negedge clk); while (!iss_ready);
        @(posedge clk); #2;
        iss_valid = 1'b0;
    endtask

    task automatic respond(input int tag, input int kind, input bit err, input string req);
        @(posedge clk); #2;
        rsp_valid = 1'b1; rsp_tag = TW'(tag); rsp_kind = 2'(kind);
        @(negedge clk);
        check(rsp_err == err, req, int'(rsp_err), int'(err));
        @(posedge clk); #2;
        rsp_valid = 1'b0;
    endtask

    task automatic probe(input int kind, input bit exp, input string req);
        @(posedge clk); #2;
        iss_kind = 2'(kind);
        @(negedge clk);
        check(iss_ready == exp, req, int'(iss_ready), int'(exp));
    endtask

    task automatic expect_item(input int tag, input int kind);
        exp_q.push_back({TW'(tag), 2'(kind)});
    endtask

    task automatic drain(input string req);
        for (int i = 0; i < 60 && exp_q.size() != 0; i++) @(negedge clk);
        check(exp_q.size() == 0, req, exp_q.size(), 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check(wb_valid == 1'b0, "R1 wb_valid after reset", int'(wb_valid), 0);
        for (int k = 0; k < 4; k++) probe(k, 1'b1, "R1 iss_ready after reset");

        // R2 / R3 / R12 program order
        issue(1, 0); expect_item(1, 0);
        issue(2, 2); expect_item(2, 2);
        issue(3, 3);
        issue(4, 1); expect_item(4, 1);
        respond(4, 1, 1'b0, "R2 response accepted");
        respond(2, 2, 1'b0, "R2 response accepted");
        repeat (3) @(negedge clk);
        check(wb_valid == 1'b0, "R3 younger done waits", int'(wb_valid), 0);
        respond(1, 0, 1'b0, "R2 response accepted");
        @(negedge clk);
        check(wb_valid == 1'b0, "R12 not yet offered", int'(wb_valid), 0);
        @(negedge clk);
        check(wb_valid && wb_tag == 8'd1, "R12 offered after next edge", int'(wb_tag), 1);
        drain("R2 program order drained");

        // R5 unmatched responses; R4 fence never delivered
        respond(9, 0, 1'b1, "R5 unknown tag flagged");
        respond(1, 0, 1'b1, "R5 retired tag flagged");
        respond(3, 3, 1'b1, "R4 fence has no slot");
        repeat (4) @(negedge clk);
        check(wb_valid == 1'b0, "R4 R5 nothing delivered", int'(wb_valid), 0);
        for (int k = 0; k < 8; k++) issue(100 + k, 3);
        probe(0, 1'b1, "R4 fences use no load credit");
        probe(2, 1'b1, "R4 fences use no store credit");

        // R8 caps, R9 release
        for (int k = 0; k < 6; k++) begin issue(10 + k, 0); expect_item(10 + k, 0); end
        probe(0, 1'b0, "R8 load capped");
        probe(1, 1'b0, "R8 atomic capped");
        probe(2, 1'b1, "R8 store still free");
        for (int k = 0; k < 6; k++) begin issue(16 + k, 2); expect_item(16 + k, 2); end
        probe(2, 1'b0, "R8 store capped");
        respond(10, 0, 1'b0, "R9 response accepted");
        repeat (3) @(negedge clk);
        probe(0, 1'b1, "R9 load credit returned");
        probe(2, 1'b0, "R9 store still capped");
        for (int k = 21; k >= 11; k--) respond(k, (k >= 16) ? 2 : 0, 1'b0, "R2 response accepted");
        drain("R2 reverse responses drained in order");

        // R11 hold under back-pressure
        wb_ready = 1'b0;
        issue(20, 0); expect_item(20, 0);
        respond(20, 0, 1'b0, "R11 response accepted");
        repeat (2) @(negedge clk);
        check(wb_valid && wb_tag == 8'd20, "R11 offered", int'(wb_tag), 20);
        repeat (3) @(negedge clk);
        check(wb_valid && wb_tag == 8'd20 && wb_kind == 2'd0, "R11 held", int'(wb_tag), 20);
        wb_ready = 1'b1;
        drain("R11 drained");

        // arrival-order mode
        @(posedge clk); #2;
        rst_n = 1'b0; mode_ooo = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst_n = 1'b1;
        wb_ready = 1'b0;
        issue(30, 0); issue(31, 0); issue(32, 2); issue(33, 2); issue(34, 1);
        respond(33, 2, 1'b0, "R6 store queued");
        respond(32, 2, 1'b0, "R6 store queued");
        respond(31, 0, 1'b0, "R6 load queued");
        respond(34, 1, 1'b0, "R6 atomic queued");
        respond(30, 0, 1'b0, "R6 load queued");
        expect_item(33, 2); expect_item(31, 0); expect_item(34, 1);
        expect_item(30, 0); expect_item(32, 2);
        @(negedge clk);
        check(wb_valid && wb_tag == 8'd33, "R11 first store held", int'(wb_tag), 33);
        wb_ready = 1'b1;
        drain("R6 R7 arrival order with load priority");

        // R10 full store queue
        wb_ready = 1'b0;
        for (int k = 0; k < 5; k++) issue(40 + k, 2);
        for (int k = 0; k < 4; k++) begin
            respond(40 + k, 2, 1'b0, "R10 store queued");
            expect_item(40 + k, 2);
        end
        respond(44, 2, 1'b1, "R10 full queue flagged");
        wb_ready = 1'b1;
        drain("R10 queued stores drained");
        repeat (4) @(negedge clk);
        check(wb_valid == 1'b0, "R10 dropped response never offered", int'(wb_valid), 0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule